// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide configuration front end of an eight-line interrupt controller. It has two addresses. It turns host writes into settings for the priority core next to it: the line mask, the vector base, the cascade map or slave identity, the trigger mode and the choice of which pending-state register is read back. The request, in-service and priority logic stays in that core. This block receives the core's pending and in-service vectors only so that it can return them on reads.

Writes at offset 0 are decoded by their data bits. A byte with bit 4 set opens a multi-step setup sequence. When bit 4 is clear, bits 4:3 select either an operation command or a read-control command. Writes at offset 1 are steered by a small sequence counter. While setup is in progress, they fill the vector base, then the cascade word, then the mode word, in turn. Which of these steps occur depends on flags captured from the opening byte. Once the sequence is idle, writes at offset 1 load the mask. A specific end-of-interrupt command appears as a one-cycle strobe with a line number, which the priority core consumes.

Top module: `pic_prog_port`

## Requirements
- R1: A write at offset 0 with bit 4 set starts setup. In the next cycle the mask is zero, the trigger-mode output equals bit 3 (1 = edge), the cascade-enable output is 1 exactly when bit 1 is 0, and bit 0 records whether a mode word will follow.
- R2: The first offset-1 write after the setup start sets the vector base to that byte with bits 2:0 forced to zero.
- R3: After the vector base, cascade mode moves to the cascade word. Single mode instead clears the cascade map and then goes to the mode word if one was requested, or to idle if not.
- R4: The cascade word is stored whole (8 bits, one per line with a slave) when parameter IS_MASTER is 1. When IS_MASTER is 0, only bits 2:0 are stored, as the slave's own identity, and the upper bits read as zero.
- R5: The cascade word goes on to the mode word if one was requested and to idle otherwise. The mode word changes no output and always returns the sequence to idle, so the next offset-1 write loads the mask.
- R6: With the sequence idle, an offset-1 write loads the full byte into the mask in the next cycle.
- R7: An offset-0 write with bits 4:3 = 00 and bits 7:5 = 3 drives the end-of-interrupt strobe high for exactly the next cycle, with the line output equal to bits 2:0.
- R8: Operation commands with any subcommand other than 3 leave the mask, the read selection and the sequence unchanged and raise no strobe.
- R9: An offset-0 write with bits 4:3 = 01 and bit 1 set selects the offset-0 readback from bit 0 (1 = pending vector, 0 = in-service vector). With bit 1 clear, the selection is unchanged.
- R10: With read enable high, offset 0 returns the selected core vector and offset 1 returns the mask, in the same cycle. With read enable low, the read data is zero.
- R11: After reset the mask, vector base, cascade map, trigger mode and cascade enable are zero, no strobe is raised and offset 0 reads the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read enable |
| addr | input | 1 | Register offset (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| core_pend | input | 8 | Pending-request vector from the priority core |
| core_insvc | input | 8 | In-service vector from the priority core |
| line_mask | output | 8 | Interrupt mask, 1 blocks a line |
| vec_base | output | 8 | Vector base, low three bits zero |
| cascade_map | output | 8 | Slave-line map (master) or own identity (slave) |
| edge_mode | output | 1 | 1 = edge triggered, 0 = level |
| cascade_en | output | 1 | 1 = cascaded configuration |
| eoi_stb | output | 1 | One-cycle specific end-of-interrupt strobe |
| eoi_line | output | 3 | Line released by the strobe |

## Verification
The bench runs all eight combinations of the trigger, single/cascade and mode-word flags in the opening byte. For each one it follows the full setup sequence. This shows whether each step is routed to the right register and whether the counter skips the cascade and mode words correctly. All 256 mask values and all 256 vector-base bytes are written, which exposes any stuck or truncated bit. The full 8-by-8 grid of subcommand and line separates the one strobing command from the seven that must be ignored. A master and a slave instance driven side by side show the two ways the cascade word is stored.

// File: rtl/pic_prog_pkg.sv
// Package: shared types and field codes for the interrupt controller
// programming port. Assumes byte-wide host accesses.
package pic_prog_pkg;

    localparam int BYTE_W = 8;

    // Setup-sequence position for offset-1 writes.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_VEC  = 2'd1,
        SEQ_CAS  = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    // Operation-command subcode that releases one named line.
    localparam logic [2:0] SUB_SPEC_EOI = 3'd3;

endpackage

// File: rtl/pic_cmd_decode.sv
// Module: pic_cmd_decode
// Classifies one host write into setup start, operation command,
// read-control command or data write. Purely combinational; assumes at
// most one write per cycle.
module pic_cmd_decode
    import pic_prog_pkg::*;
(
    input  logic              wr_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              start_wr,
    output logic              op_wr,
    output logic              rdctl_wr,
    output logic              data_wr
);

    // Split offset-0 writes by data bits 4:3; offset-1 writes are data.
    always_comb begin
        start_wr = wr_en && !addr && wdata[4];
        op_wr    = wr_en && !addr && (wdata[4:3] == 2'b00);
        rdctl_wr = wr_en && !addr && (wdata[4:3] == 2'b01);
        data_wr  = wr_en && addr;
    end

endmodule

// File: rtl/pic_init_seq.sv
// Module: pic_init_seq
// Setup-sequence counter and the setup-time configuration it fills:
// trigger mode, cascade enable, mode-word request, vector base and the
// cascade word. IS_MASTER picks how the cascade word is kept.
// Assumes start_wr and data_wr are never high together.
module pic_init_seq
    import pic_prog_pkg::*;
#(
    parameter int LINES     = 8,
    parameter bit IS_MASTER = 1'b1,
    localparam int LINE_W   = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              seq_idle,
    output logic [BYTE_W-1:0] vec_base,
    output logic [LINES-1:0]  cascade_map,
    output logic              edge_mode,
    output logic              cascade_en
);

    seq_t             seq_q;
    logic             want_mode_q;
    logic [LINES-1:0] cas_val;

    // Select how the cascade word is captured for this variant.
    generate
        if (IS_MASTER) begin : g_master
            always_comb cas_val = wdata[LINES-1:0];
        end else begin : g_slave
            always_comb cas_val = {{(LINES-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
        end
    endgenerate

    // Advance the setup sequence and capture each setup word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= SEQ_IDLE;
            want_mode_q <= 1'b0;
            edge_mode   <= 1'b0;
            cascade_en  <= 1'b0;
            vec_base    <= '0;
            cascade_map <= '0;
        end else if (start_wr) begin
            edge_mode   <= wdata[3];
            cascade_en  <= !wdata[1];
            want_mode_q <= wdata[0];
            seq_q       <= SEQ_VEC;
        end else if (data_wr) begin
            case (seq_q)
                SEQ_VEC: begin
                    vec_base <= {wdata[BYTE_W-1:LINE_W], {LINE_W{1'b0}}};
                    if (cascade_en) begin
                        seq_q <= SEQ_CAS;
                    end else begin
                        cascade_map <= '0;
                        seq_q       <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
                    end
                end
                SEQ_CAS: begin
                    cascade_map <= cas_val;
                    seq_q       <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
                end
                SEQ_MODE: seq_q <= SEQ_IDLE;
                default:  seq_q <= SEQ_IDLE;
            endcase
        end
    end

    // Tell the run-time register block when offset 1 means the mask.
    always_comb seq_idle = (seq_q == SEQ_IDLE);

    AST_VEC_STEP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seq_q == SEQ_VEC) |=> (seq_q != SEQ_VEC)); // R3
    AST_CAS_ONLY_CASCADED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_CAS) |-> cascade_en); // R3
    AST_MODE_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_MODE) |-> want_mode_q); // R5
    AST_MODE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && seq_q == SEQ_MODE) |=> seq_idle); // R5

endmodule

// File: rtl/pic_run_regs.sv
// Module: pic_run_regs
// Run-time registers: line mask, readback selection and the registered
// specific end-of-interrupt strobe. Assumes decoded write classes come
// from pic_cmd_decode and seq_idle from pic_init_seq.
module pic_run_regs
    import pic_prog_pkg::*;
#(
    parameter int LINES   = 8,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              op_wr,
    input  logic              rdctl_wr,
    input  logic              data_wr,
    input  logic              seq_idle,
    input  logic [BYTE_W-1:0] wdata,
    output logic [LINES-1:0]  line_mask,
    output logic              sel_pend,
    output logic              eoi_stb,
    output logic [LINE_W-1:0] eoi_line
);

    logic mask_wr;
    logic eoi_hit;

    // Decide which run-time updates this write causes.
    always_comb begin
        mask_wr = data_wr && seq_idle;
        eoi_hit = op_wr && (wdata[7:5] == SUB_SPEC_EOI);
    end

    // Hold the mask: cleared by setup start, loaded when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        line_mask <= '0;
        else if (start_wr) line_mask <= '0;
        else if (mask_wr)  line_mask <= wdata[LINES-1:0];
    end

    // Hold the readback selection, changed only by an enabled read-control.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sel_pend <= 1'b1;
        else if (rdctl_wr && wdata[1])  sel_pend <= wdata[0];
    end

    // Issue a one-cycle strobe for a specific end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_stb  <= 1'b0;
            eoi_line <= '0;
        end else begin
            eoi_stb <= eoi_hit;
            if (eoi_hit) eoi_line <= wdata[LINE_W-1:0];
        end
    end

    AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (line_mask == '0)); // R1
    AST_IDLE_LOADS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (line_mask == $past(wdata[LINES-1:0]))); // R6
    AST_EOI_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb |-> $past(op_wr && wdata[7:5] == SUB_SPEC_EOI)); // R7
    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rdctl_wr |=> $stable(sel_pend)); // R9

endmodule

// File: rtl/pic_prog_port.sv
// Module: pic_prog_port (top)
// Two-offset byte port of an eight-line interrupt controller: decodes
// writes, runs the setup sequence, holds configuration and returns
// pending, in-service or mask bytes on reads. Assumes single-byte
// accesses and a synchronous active-low reset.
module pic_prog_port
    import pic_prog_pkg::*;
#(
    parameter int LINES     = 8,
    parameter bit IS_MASTER = 1'b1,
    localparam int LINE_W   = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [LINES-1:0]  core_pend,
    input  logic [LINES-1:0]  core_insvc,
    output logic [LINES-1:0]  line_mask,
    output logic [BYTE_W-1:0] vec_base,
    output logic [LINES-1:0]  cascade_map,
    output logic              edge_mode,
    output logic              cascade_en,
    output logic              eoi_stb,
    output logic [LINE_W-1:0] eoi_line
);

    logic start_wr, op_wr, rdctl_wr, data_wr;
    logic seq_idle, sel_pend;

    pic_cmd_decode u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .start_wr (start_wr),
        .op_wr    (op_wr),
        .rdctl_wr (rdctl_wr),
        .data_wr  (data_wr)
    );

    pic_init_seq #(.LINES(LINES), .IS_MASTER(IS_MASTER)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (start_wr),
        .data_wr     (data_wr),
        .wdata       (wdata),
        .seq_idle    (seq_idle),
        .vec_base    (vec_base),
        .cascade_map (cascade_map),
        .edge_mode   (edge_mode),
        .cascade_en  (cascade_en)
    );

    pic_run_regs #(.LINES(LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .op_wr     (op_wr),
        .rdctl_wr  (rdctl_wr),
        .data_wr   (data_wr),
        .seq_idle  (seq_idle),
        .wdata     (wdata),
        .line_mask (line_mask),
        .sel_pend  (sel_pend),
        .eoi_stb   (eoi_stb),
        .eoi_line  (eoi_line)
    );

    // Return the addressed byte while read enable is high, else zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr)          rdata[LINES-1:0] = line_mask;
            else if (sel_pend) rdata[LINES-1:0] = core_pend;
            else               rdata[LINES-1:0] = core_insvc;
        end
    end

    AST_READ_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0)); // R10

endmodule

// File: tb/pic_prog_port_bench.sv
// Bench for pic_prog_port: sweeps setup flags, mask and vector bytes and
// the subcommand/line grid; expected values are computed here.
module pic_prog_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] core_pend = 8'hA5;
    logic [7:0] core_insvc = 8'h5A;

    logic [7:0] rdata, line_mask, vec_base, cascade_map;
    logic       edge_mode, cascade_en, eoi_stb;
    logic [2:0] eoi_line;
    logic [7:0] s_rdata, s_mask, s_vec, s_map;
    logic       s_edge, s_casc, s_stb;
    logic [2:0] s_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    pic_prog_port u_pic_prog_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .core_pend(core_pend),
        .core_insvc(core_insvc), .line_mask(line_mask), .vec_base(vec_base),
        .cascade_map(cascade_map), .edge_mode(edge_mode),
        .cascade_en(cascade_en), .eoi_stb(eoi_stb), .eoi_line(eoi_line)
    );

    pic_prog_port #(.IS_MASTER(1'b0)) u_pic_prog_port_slv (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(s_rdata), .core_pend(core_pend),
        .core_insvc(core_insvc), .line_mask(s_mask), .vec_base(s_vec),
        .cascade_map(s_map), .edge_mode(s_edge),
        .cascade_en(s_casc), .eoi_stb(s_stb), .eoi_line(s_line)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Write one byte; returns at the negedge after the capturing edge.
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Combinational read between edges.
    task automatic rd(input logic a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #2;
        d = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_mask;
        logic [7:0] exp_vec;
        logic       exp_sel;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 mask", line_mask, 0);
        check("R11 vec", vec_base, 0);
        check("R11 map", cascade_map, 0);
        check("R11 edge", edge_mode, 0);
        check("R11 casc", cascade_en, 0);
        check("R11 stb", eoi_stb, 0);
        rd(1'b0, r);
        check("R11 read selects pending", r, 8'hA5);

        // R6, R10: full mask sweep with idle sequence
        for (int v = 0; v < 256; v++) begin
            wr(1'b1, 8'(v));
            check("R6 mask load", line_mask, v);
            rd(1'b1, r);
            check("R10 read mask", r, v);
        end
        exp_mask = 8'hFF;

        // R1..R5: all opening-byte flag combinations
        for (int f = 0; f < 8; f++) begin
            logic e, single, m4;
            logic [7:0] icw, vb, cw;
            e = f[2]; single = f[1]; m4 = f[0];
            icw = 8'h10 | {4'b0, e, 1'b0, single, m4};
            wr(1'b0, icw);
            check("R1 mask cleared", line_mask, 0);
            check("R1 edge", edge_mode, e);
            check("R1 cascade", cascade_en, !single);
            vb = 8'((f * 37 + 3) & 8'hFF);
            wr(1'b1, vb);
            exp_vec = vb & 8'hF8;
            check("R2 vec base", vec_base, exp_vec);
            check("R2 vec base slave", s_vec, exp_vec);
            check("R2 mask untouched", line_mask, 0);
            if (!single) begin
                cw = 8'hC3 ^ 8'(f * 16 + f);
                wr(1'b1, cw);
                check("R4 master map", cascade_map, cw);
                check("R4 slave id", s_map, cw & 8'h07);
                check("R5 mask untouched", line_mask, 0);
            end else begin
                check("R3 single clears map", cascade_map, 0);
                check("R3 single clears slave map", s_map, 0);
            end
            if (m4) begin
                wr(1'b1, 8'h1D);
                check("R5 mode word leaves mask", line_mask, 0);
                check("R5 mode word leaves vec", vec_base, exp_vec);
            end
            exp_mask = 8'h5A ^ 8'(f);
            wr(1'b1, exp_mask);
            check("R5 back to idle mask", line_mask, exp_mask);
            check("R5 vec kept", vec_base, exp_vec);
        end

        // R2: full vector-base byte sweep (single, no mode word)
        for (int v = 0; v < 256; v++) begin
            wr(1'b0, 8'h12);
            wr(1'b1, 8'(v));
            check("R2 vec sweep", vec_base, v & 8'hF8);
        end
        exp_mask = 8'h3C;
        wr(1'b1, exp_mask);
        check("R6 mask after sweep", line_mask, exp_mask);

        // R7, R8: subcommand x line grid
        exp_sel = 1'b1;
        for (int sc = 0; sc < 8; sc++) begin
            for (int ln = 0; ln < 8; ln++) begin
                wr(1'b0, 8'((sc << 5) | ln));
                if (sc == 3) begin
                    check("R7 strobe", eoi_stb, 1);
                    check("R7 line", eoi_line, ln);
                end else begin
                    check("R8 no strobe", eoi_stb, 0);
                end
                check("R8 mask kept", line_mask, exp_mask);
                @(negedge clk);
                check("R7 strobe one cycle", eoi_stb, 0);
                rd(1'b0, r);
                check("R8 read select kept", r, 8'hA5);
            end
        end
        wr(1'b1, 8'h81);
        check("R8 sequence still idle", line_mask, 8'h81);

        // R9, R10: read-control combinations
        wr(1'b0, 8'h0A);
        rd(1'b0, r); check("R9 select in-service", r, 8'h5A);
        wr(1'b0, 8'h09);
        rd(1'b0, r); check("R9 bit1 clear keeps", r, 8'h5A);
        core_insvc = 8'h0F;
        rd(1'b0, r); check("R10 follows in-service", r, 8'h0F);
        wr(1'b0, 8'h0B);
        rd(1'b0, r); check("R9 select pending", r, 8'hA5);
        wr(1'b0, 8'h08);
        rd(1'b0, r); check("R9 bit1 clear keeps pending", r, 8'hA5);
        rd_en = 1'b0; addr = 1'b1; #2;
        check("R10 no read enable", rdata, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule